// File: doc/BRIEF.md
# Sprite Table Copy DMA Engine

This block copies a fixed-size table of sprite attributes from main memory into on-chip object memory. Software starts a copy with one byte written to a start register in the I/O page. That byte becomes the high byte of the source address, and the low byte is always zero, so every copy begins on a 256-byte page boundary. The engine then fetches 160 bytes in ascending order through a source read port. It writes each byte to the object memory window at 0xFE00 through a destination write port. The copy takes 671 clocks.

While the copy runs, the engine drives a grant signal for the CPU's current address. The CPU is allowed only into the small high scratch RAM window at 0xFF80–0xFFFE, and every other address is denied until the copy ends. The engine counts in CPU clocks, so in double-speed mode the cycle count stays the same and the wall time is halved. A page that lies above the valid source range, at 0xE000 or higher, is never put on the read port, and the engine writes 0xFF for each of its bytes.

Top module: `sprite_dma`

## Requirements
- R1: After reset `busy_o`, `src_rd_o` and `dst_we_o` are low and `cpu_grant_o` is high for any address.
- R2: A copy starts only when `cfg_wr_i` is high and `cfg_addr_i` equals 0x46. A write to any other offset leaves `busy_o` low and issues no strobes.
- R3: The source read for byte k (k = 0..159, ascending) drives `src_addr_o` = {page, k[7:0]} with `src_rd_o` high for one clock. `src_rdata_i` is expected one clock after the strobe.
- R4: The write for byte k drives `dst_addr_o` = 0xFE00 + k with `dst_we_o` high for one clock, in the clock right after its read. `dst_wdata_o` carries the byte returned for that read.
- R5: Let edge 0 be the clock edge that samples the start write. `busy_o` is then high for exactly 671 clocks, and the write for byte k appears in clock 34 + 4k after edge 0. This comes from a 31-clock lead-in followed by one byte every 4 clocks.
- R6: Each copy performs exactly 160 destination writes, and the last of them falls in the final busy clock.
- R7: A start write during a copy abandons it and restarts from byte 0 with the new page. The full 671-clock timing is counted again from the new start edge.
- R8: If the page is 0xE0 or higher, `src_rd_o` stays low for the whole copy and every destination write carries 0xFF.
- R9: While `busy_o` is high, `cpu_grant_o` is high only for `cpu_addr_i` in 0xFF80–0xFFFE. While idle it is high for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cfg_wr_i | input | 1 | I/O register write strobe |
| cfg_addr_i | input | 8 | I/O register offset |
| cfg_wdata_i | input | 8 | I/O write data (source page on a start write) |
| cpu_addr_i | input | 16 | Address the CPU is currently requesting |
| cpu_grant_o | output | 1 | CPU access allowed for `cpu_addr_i` |
| src_rd_o | output | 1 | Source read strobe |
| src_addr_o | output | 16 | Source read address |
| src_rdata_i | input | 8 | Source data, valid one clock after the strobe |
| dst_we_o | output | 1 | Object memory write strobe |
| dst_addr_o | output | 16 | Object memory write address |
| dst_wdata_o | output | 8 | Object memory write data |
| busy_o | output | 1 | Copy in progress |

## Verification
A wrong lead-in or byte counter shows at the ports within one byte slot. It moves the first write off clock 34 or breaks the 4-clock spacing between writes. It also changes the 671-clock busy length, which the bench measures against the start edge. A stale source page or a lost fetch flag shows up in the very first byte written: it gives a wrong address, source data where 0xFF belongs, or 0xFF where source data belongs. A grant fault is visible combinationally in the same clock as the probed address.

// File: rtl/sprite_dma_pkg.sv
package sprite_dma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LEAD = 2'd1,
      ST_COPY = 2'd2
   } copy_state_e;

   localparam int unsigned DEF_ENTRIES  = 160;
   localparam int unsigned DEF_LEAD_IN  = 31;
   localparam int unsigned DEF_INTERVAL = 4;

endpackage

// File: rtl/sprite_dma_pacer.sv
module sprite_dma_pacer
   import sprite_dma_pkg::*;
#(
   parameter int unsigned ENTRIES  = DEF_ENTRIES,
   parameter int unsigned LEAD_IN  = DEF_LEAD_IN,
   parameter int unsigned INTERVAL = DEF_INTERVAL,
   localparam int unsigned IDX_W   = $clog2(ENTRIES),
   localparam int unsigned LEAD_W  = $clog2(LEAD_IN + 1),
   localparam int unsigned PH_W    = $clog2(INTERVAL)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   output logic             busy_o,
   output logic             rd_stb_o,
   output logic             wr_stb_o,
   output logic [IDX_W-1:0] idx_o
);

   localparam logic [LEAD_W-1:0] LeadLast = LEAD_W'(LEAD_IN - 1);
   localparam logic [PH_W-1:0]   PhRead   = PH_W'(INTERVAL - 2);
   localparam logic [PH_W-1:0]   PhWrite  = PH_W'(INTERVAL - 1);
   localparam logic [IDX_W-1:0]  IdxLast  = IDX_W'(ENTRIES - 1);

   copy_state_e      st_q;
   logic [LEAD_W-1:0] lead_q;
   logic [PH_W-1:0]  ph_q;
   logic [IDX_W-1:0] idx_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         lead_q <= '0;
         ph_q   <= '0;
         idx_q  <= '0;
      end else if (start_i) begin
         st_q   <= ST_LEAD;
         lead_q <= '0;
         ph_q   <= '0;
         idx_q  <= '0;
      end else begin
         unique case (st_q)
            ST_LEAD: begin
               if (lead_q == LeadLast) st_q <= ST_COPY;
               else                    lead_q <= lead_q + 1'b1;
            end
            ST_COPY: begin
               if (ph_q == PhWrite) begin
                  ph_q <= '0;
                  if (idx_q == IdxLast) st_q  <= ST_IDLE;
                  else                  idx_q <= idx_q + 1'b1;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   assign busy_o   = (st_q != ST_IDLE);
   assign rd_stb_o = (st_q == ST_COPY) && (ph_q == PhRead);
   assign wr_stb_o = (st_q == ST_COPY) && (ph_q == PhWrite);
   assign idx_o    = idx_q;

endmodule

// File: rtl/sprite_dma_fetch.sv
module sprite_dma_fetch #(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_W     = 8,
   parameter int unsigned IDX_W      = 8,
   parameter int unsigned LIMIT_PAGE = 'hE0,
   parameter logic [DATA_W-1:0] FILL = '1,
   localparam int unsigned OFS_W     = ADDR_W - PAGE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [PAGE_W-1:0] page_i,
   input  logic              rd_stb_i,
   input  logic [IDX_W-1:0]  idx_i,
   input  logic [DATA_W-1:0] rdata_i,
   output logic              rd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] wdata_o
);

   logic [PAGE_W-1:0] page_q;
   logic              fetched_q;
   logic              page_ok;

   generate
      if (LIMIT_PAGE >= (1 << PAGE_W)) begin : g_no_limit
         assign page_ok = 1'b1;
      end else begin : g_limit
         assign page_ok = (page_q < PAGE_W'(LIMIT_PAGE));
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         page_q    <= '0;
         fetched_q <= 1'b0;
      end else if (start_i) begin
         page_q    <= page_i;
         fetched_q <= 1'b0;
      end else begin
         fetched_q <= rd_stb_i && page_ok;
      end
   end

   assign rd_o    = rd_stb_i && page_ok;
   assign addr_o  = {page_q, OFS_W'(idx_i)};
   assign wdata_o = fetched_q ? rdata_i : FILL;

endmodule

// File: rtl/sprite_dma_arb.sv
module sprite_dma_arb #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] WIN_LO = 16'hFF80,
   parameter logic [ADDR_W-1:0] WIN_HI = 16'hFFFE
) (
   input  logic              busy_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   output logic              grant_o
);

   logic in_win;
   assign in_win  = (cpu_addr_i >= WIN_LO) && (cpu_addr_i <= WIN_HI);
   assign grant_o = !busy_i || in_win;

endmodule

// File: rtl/sprite_dma.sv
module sprite_dma
   import sprite_dma_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned REG_W      = 8,
   parameter logic [7:0]  START_OFS  = 8'h46,
   parameter int unsigned ENTRIES    = DEF_ENTRIES,
   parameter int unsigned LEAD_IN    = DEF_LEAD_IN,
   parameter int unsigned INTERVAL   = DEF_INTERVAL,
   parameter int unsigned LIMIT_PAGE = 'hE0,
   parameter logic [15:0] DST_BASE   = 16'hFE00,
   parameter logic [15:0] WIN_LO     = 16'hFF80,
   parameter logic [15:0] WIN_HI     = 16'hFFFE,
   localparam int unsigned PAGE_W    = DATA_W,
   localparam int unsigned IDX_W     = $clog2(ENTRIES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_wr_i,
   input  logic [REG_W-1:0]  cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   output logic              cpu_grant_o,
   output logic              src_rd_o,
   output logic [ADDR_W-1:0] src_addr_o,
   input  logic [DATA_W-1:0] src_rdata_i,
   output logic              dst_we_o,
   output logic [ADDR_W-1:0] dst_addr_o,
   output logic [DATA_W-1:0] dst_wdata_o,
   output logic              busy_o
);

   generate
      if (INTERVAL < 2) begin : g_bad_interval
         $error("INTERVAL must be at least 2");
      end
      if (LEAD_IN < 1) begin : g_bad_lead
         $error("LEAD_IN must be at least 1");
      end
      if (IDX_W > ADDR_W - PAGE_W) begin : g_bad_entries
         $error("ENTRIES must fit inside one source page");
      end
   endgenerate

   logic             start;
   logic             rd_stb;
   logic             wr_stb;
   logic [IDX_W-1:0] idx;

   assign start = cfg_wr_i && (cfg_addr_i == REG_W'(START_OFS));

   sprite_dma_pacer #(
      .ENTRIES  (ENTRIES),
      .LEAD_IN  (LEAD_IN),
      .INTERVAL (INTERVAL)
   ) u_pacer (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .busy_o   (busy_o),
      .rd_stb_o (rd_stb),
      .wr_stb_o (wr_stb),
      .idx_o    (idx)
   );

   sprite_dma_fetch #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .PAGE_W     (PAGE_W),
      .IDX_W      (IDX_W),
      .LIMIT_PAGE (LIMIT_PAGE)
   ) u_fetch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .start_i  (start),
      .page_i   (cfg_wdata_i),
      .rd_stb_i (rd_stb),
      .idx_i    (idx),
      .rdata_i  (src_rdata_i),
      .rd_o     (src_rd_o),
      .addr_o   (src_addr_o),
      .wdata_o  (dst_wdata_o)
   );

   sprite_dma_arb #(
      .ADDR_W (ADDR_W),
      .WIN_LO (ADDR_W'(WIN_LO)),
      .WIN_HI (ADDR_W'(WIN_HI))
   ) u_arb (
      .busy_i     (busy_o),
      .cpu_addr_i (cpu_addr_i),
      .grant_o    (cpu_grant_o)
   );

   assign dst_we_o   = wr_stb;
   assign dst_addr_o = ADDR_W'(DST_BASE) + ADDR_W'(idx);

endmodule

// File: rtl/sprite_dma_chk.sv
module sprite_dma_chk #(
   parameter logic [7:0]  START_OFS = 8'h46,
   parameter logic [15:0] DST_BASE  = 16'hFE00,
   parameter int unsigned ENTRIES   = 160,
   parameter logic [7:0]  LIMIT_PG  = 8'hE0,
   parameter logic [15:0] WIN_LO    = 16'hFF80,
   parameter logic [15:0] WIN_HI    = 16'hFFFE
) (
   input logic        clk_i,
   input logic        rst_ni,
   input logic        cfg_wr_i,
   input logic [7:0]  cfg_addr_i,
   input logic [15:0] cpu_addr_i,
   input logic        cpu_grant_o,
   input logic        src_rd_o,
   input logic [15:0] src_addr_o,
   input logic [7:0]  src_rdata_i,
   input logic        dst_we_o,
   input logic [15:0] dst_addr_o,
   input logic [7:0]  dst_wdata_o,
   input logic        busy_o
);

   logic start_seen;
   assign start_seen = cfg_wr_i && (cfg_addr_i == START_OFS);

   p_quiet_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> (!src_rd_o && !dst_we_o));

   p_start_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_seen |=> busy_o);

   p_read_then_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (src_rd_o && !start_seen) |=> dst_we_o);

   p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(src_rd_o && dst_we_o));

   p_wdata_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_we_o && $past(src_rd_o)) |-> (dst_wdata_o == src_rdata_i));

   p_dst_window_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dst_we_o |-> ((dst_addr_o >= DST_BASE) && (dst_addr_o < DST_BASE + 16'(ENTRIES))));

   p_src_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      src_rd_o |-> (src_addr_o[15:8] < LIMIT_PG));

   p_fill_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_we_o && !$past(src_rd_o)) |-> (dst_wdata_o == 8'hFF));

   p_lockout_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && !((cpu_addr_i >= WIN_LO) && (cpu_addr_i <= WIN_HI))) |-> !cpu_grant_o);

   p_idle_grant_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !busy_o |-> cpu_grant_o);

endmodule

bind sprite_dma sprite_dma_chk u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cfg_wr_i    (cfg_wr_i),
   .cfg_addr_i  (cfg_addr_i),
   .cpu_addr_i  (cpu_addr_i),
   .cpu_grant_o (cpu_grant_o),
   .src_rd_o    (src_rd_o),
   .src_addr_o  (src_addr_o),
   .src_rdata_i (src_rdata_i),
   .dst_we_o    (dst_we_o),
   .dst_addr_o  (dst_addr_o),
   .dst_wdata_o (dst_wdata_o),
   .busy_o      (busy_o)
);

// File: tb/sprite_dma_tb.sv
module sprite_dma_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // bit 8: page expected readable, bits 7:0: page
   localparam logic [8:0] VEC [NVEC] = '{
      {1'b1, 8'h00}, {1'b1, 8'hC0}, {1'b1, 8'h45},
      {1'b1, 8'hDF}, {1'b0, 8'hE0}, {1'b0, 8'hFF}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [15:0] cpu_addr = 16'hC000;
   logic        cpu_grant;
   logic        src_rd;
   logic [15:0] src_addr;
   logic [7:0]  src_rdata = '0;
   logic        dst_we;
   logic [15:0] dst_addr;
   logic [7:0]  dst_wdata;
   logic        busy;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   sprite_dma dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .cfg_wr_i    (cfg_wr),
      .cfg_addr_i  (cfg_addr),
      .cfg_wdata_i (cfg_wdata),
      .cpu_addr_i  (cpu_addr),
      .cpu_grant_o (cpu_grant),
      .src_rd_o    (src_rd),
      .src_addr_o  (src_addr),
      .src_rdata_i (src_rdata),
      .dst_we_o    (dst_we),
      .dst_addr_o  (dst_addr),
      .dst_wdata_o (dst_wdata),
      .busy_o      (busy)
   );

   function automatic logic [7:0] pat(input logic [15:0] a);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
   endfunction

   // source memory model: one clock read latency
   always @(posedge clk) if (src_rd) src_rdata <= pat(src_addr);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // ends in the cycle t=0 sampling point (after edge 0)
   task automatic start_copy(input logic [7:0] ofs, input logic [7:0] page);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = page;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_addr = '0;
   endtask

   task automatic collect(input logic [7:0] page, input bit ok_page);
      int nrd = 0;
      int nwr = 0;
      int busy_cnt = 0;
      int first_wr = -1;
      int last_wr = -1;
      for (int t = 0; t < 720; t++) begin
         if (busy) busy_cnt++;
         if (src_rd) begin
            chk(src_addr == {page, 8'(nrd)}, "R3 src address", src_addr, {page, 8'(nrd)});
            nrd++;
         end
         if (dst_we) begin
            if (first_wr < 0) first_wr = t;
            chk(t == 34 + 4 * nwr, "R5 write slot", t, 34 + 4 * nwr);
            chk(dst_addr == 16'hFE00 + 16'(nwr), "R4 dst address", dst_addr, 16'hFE00 + 16'(nwr));
            if (ok_page)
               chk(dst_wdata == pat({page, 8'(nwr)}), "R4 dst data", dst_wdata, pat({page, 8'(nwr)}));
            else
               chk(dst_wdata == 8'hFF, "R8 fill data", dst_wdata, 8'hFF);
            last_wr = t;
            nwr++;
         end
         @(negedge clk);
      end
      chk(busy_cnt == 671, "R5 busy length", busy_cnt, 671);
      chk(first_wr == 34, "R5 first write", first_wr, 34);
      chk(nwr == 160, "R6 write count", nwr, 160);
      chk(last_wr == 670, "R6 last write in last busy clock", last_wr, 670);
      chk(nrd == (ok_page ? 160 : 0), ok_page ? "R3 read count" : "R8 no reads", nrd, ok_page ? 160 : 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !src_rd && !dst_we, "R1 reset quiet", {busy, src_rd, dst_we}, 0);
      chk(cpu_grant, "R1 grant in reset", cpu_grant, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy, "R1 idle after reset", busy, 0);

      // vector table walk
      for (int i = 0; i < NVEC; i++) begin
         start_copy(8'h46, VEC[i][7:0]);
         collect(VEC[i][7:0], VEC[i][8]);
      end

      // R2: other offsets are ignored
      start_copy(8'h47, 8'hC0);
      begin
         int seen = 0;
         for (int t = 0; t < 40; t++) begin
            if (busy || src_rd || dst_we) seen++;
            @(negedge clk);
         end
         chk(seen == 0, "R2 wrong offset ignored", seen, 0);
      end

      // R9: lockout during a copy, idle grant
      start_copy(8'h46, 8'h10);
      repeat (50) @(negedge clk);
      cpu_addr = 16'hC000; #1 chk(!cpu_grant, "R9 work RAM denied", cpu_grant, 0);
      cpu_addr = 16'hFE00; #1 chk(!cpu_grant, "R9 object memory denied", cpu_grant, 0);
      cpu_addr = 16'hFF7F; #1 chk(!cpu_grant, "R9 below window denied", cpu_grant, 0);
      cpu_addr = 16'hFF80; #1 chk(cpu_grant, "R9 window low granted", cpu_grant, 1);
      cpu_addr = 16'hFFFE; #1 chk(cpu_grant, "R9 window high granted", cpu_grant, 1);
      cpu_addr = 16'hFFFF; #1 chk(!cpu_grant, "R9 above window denied", cpu_grant, 0);
      while (busy) @(negedge clk);
      cpu_addr = 16'hC000; #1 chk(cpu_grant, "R9 idle granted", cpu_grant, 1);

      // R7: restart mid-copy with a new page
      start_copy(8'h46, 8'hC0);
      repeat (200) @(negedge clk);
      start_copy(8'h46, 8'h21);
      collect(8'h21, 1'b1);
      // R7: restart during the lead-in
      start_copy(8'h46, 8'h80);
      repeat (10) @(negedge clk);
      start_copy(8'h46, 8'hE5);
      collect(8'hE5, 1'b0);

      // R1: reset in mid-copy returns to idle
      start_copy(8'h46, 8'h30);
      repeat (100) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !dst_we && !src_rd, "R1 reset aborts copy", {busy, src_rd, dst_we}, 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule